// File: doc/BRIEF.md
# Serial EEPROM Host Controller

This block is the master side of a three-wire serial link to a 256-word by 16-bit EEPROM. A client hands it one command at a time: an operation code, a word address, a write word and, for reads, a word count. The controller builds the serial frame, produces the chip select and a divided serial clock, shifts the frame out most significant bit first and, for reads, assembles the returned bits into words. Each word is presented with a one-cycle strobe and the address it came from.

For the four program-type operations (single write, single erase, erase-all, write-all), the controller releases chip select after the frame for a programmable minimum time. It then selects the memory again and samples its data output until the memory reports ready. It then clocks one 1 bit so that the memory releases its output, deselects, and reports completion. A programmable poll limit bounds the wait. When the limit is reached, completion is reported with an error flag.

Top module: `ee_serial_host`

## Requirements
- R1: A request is taken only when `req_valid` is high and `busy` is low. `busy` stays high from the cycle after acceptance until the cycle `done` pulses. A request presented while `busy` is high is dropped and has no effect on the memory.
- R2: Every frame is a 1 start bit, a 2-bit opcode and 8 address bits, all MSB first. WRITE and WRAL frames then carry 16 data bits. Opcodes: read 10, write 01, erase 11, all others 00. The top two address bits for the 00 group are enable 11, disable 00, erase-all 10 and write-all 01, and the other six address bits are 0. `req_op` codes: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all.
- R3: Each serial clock half period lasts at least DIV system clocks. `mem_di` is stable at every rising serial clock edge. The serial clock is low whenever chip select changes.
- R4: A read skips the single leading dummy 0 bit. It then returns `req_count` 16-bit words, MSB first and back to back, each with a one-cycle `rd_valid` pulse.
- R5: `rd_addr` gives each returned word's address, which increases by one per word and wraps from 255 to 0.
- R6: After a program-type frame, chip select stays low for at least CSMIN system clocks before it rises again for polling.
- R7: Polling ends when `mem_do` reads 1. The controller then gives exactly one serial clock pulse with `mem_di` high, drops chip select, and after the deselect gap pulses `done` with `err` low.
- R8: If POLL_LIM polls read 0, chip select drops and `done` pulses together with `err` high.
- R9: Enable and disable frames finish without polling, with chip select raised only once for the command.
- R10: A read with count 0, or op code 7, raises no chip select and pulses `done` on the cycle after acceptance. Code 7 also raises `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 8 | Word address |
| req_wdata | input | 16 | Word for write / write-all |
| req_count | input | 9 | Number of words to read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout or bad op, valid with done |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word |
| rd_addr | output | 8 | Address of the read word |
| mem_cs | output | 1 | Chip select to memory |
| mem_sk | output | 1 | Serial clock to memory |
| mem_di | output | 1 | Serial data to memory |
| mem_do | input | 1 | Serial data from memory |

## Verification
A wrong bit count or a misplaced sample point shows on the first read word as data shifted by one position. The word address tracker falling out of step shows as a wrong `rd_addr` on the first word past 255. A deselect or poll sequencing fault shows in the same command: the gap before the poll is too short, the release pulse is missing, or `done` arrives without the memory having become ready. A lost or extra busy state shows either as a stray frame from a refused request or as the next command hanging.

// File: rtl/ee_serial_host.sv
module ee_serial_host #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int CW       = 9,
  parameter int DIV      = 4,
  parameter int CSMIN    = 16,
  parameter int POLL_LIM = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] req_count,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          mem_cs,
  output logic          mem_sk,
  output logic          mem_di,
  input  logic          mem_do
);
  localparam int FW  = 3 + AW + DW;
  localparam int NW  = $clog2(FW + 1);
  localparam int DVW = $clog2(DIV + 1);
  localparam int GW  = $clog2(CSMIN + 1);
  localparam int PW  = $clog2(POLL_LIM + 1);
  localparam int BW  = $clog2(DW);

  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_ER = 3'd2, OP_EN = 3'd3,
                         OP_DS = 3'd4, OP_EA = 3'd5, OP_WA = 3'd6, OP_BAD = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_READ, S_GAP, S_POLL, S_CLR} st_t;

  st_t            state;
  logic [FW-1:0]  sh, frame;
  logic [NW-1:0]  bitn, flen;
  logic [DVW-1:0] dcnt;
  logic [GW-1:0]  gcnt;
  logic [PW-1:0]  pcnt;
  logic [CW-1:0]  words;
  logic [AW-1:0]  raddr, afld;
  logic [DW-1:0]  rsh;
  logic [BW-1:0]  rbit;
  logic [1:0]     opc;
  logic           is_rd, prog, polled, tmo, has_data, prog_op;

  wire run  = (state == S_SEND) || (state == S_READ) || (state == S_POLL) || (state == S_CLR);
  wire tick = (dcnt == DVW'(DIV - 1));

  assign busy     = (state != S_IDLE);
  assign mem_di   = (state == S_CLR) || ((state == S_SEND) && sh[FW-1]);
  assign has_data = (req_op == OP_WR) || (req_op == OP_WA);
  assign prog_op  = has_data || (req_op == OP_ER) || (req_op == OP_EA);
  assign flen     = has_data ? NW'(FW) : NW'(FW - DW);
  assign frame    = {1'b1, opc, afld, (has_data ? req_wdata : {DW{1'b0}})};

  always_comb begin
    opc  = 2'b00;
    afld = req_addr;
    case (req_op)
      OP_RD:   opc = 2'b10;
      OP_WR:   opc = 2'b01;
      OP_ER:   opc = 2'b11;
      OP_EN:   afld = {2'b11, {(AW-2){1'b0}}};
      OP_DS:   afld = {2'b00, {(AW-2){1'b0}}};
      OP_EA:   afld = {2'b10, {(AW-2){1'b0}}};
      default: afld = {2'b01, {(AW-2){1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              dcnt <= '0;
    else if (run && !tick)   dcnt <= dcnt + DVW'(1);
    else                     dcnt <= '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sh <= '0; bitn <= '0; gcnt <= '0; pcnt <= '0;
      words <= '0; raddr <= '0; rsh <= '0; rbit <= '0;
      is_rd <= 1'b0; prog <= 1'b0; polled <= 1'b0; tmo <= 1'b0;
      mem_cs <= 1'b0; mem_sk <= 1'b0;
      done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0; rd_data <= '0; rd_addr <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (req_op == OP_BAD || (req_op == OP_RD && req_count == '0)) begin
            done <= 1'b1;
            err  <= (req_op == OP_BAD);
          end else begin
            state  <= S_SEND;
            mem_cs <= 1'b1;
            mem_sk <= 1'b0;
            sh     <= frame;
            bitn   <= flen;
            is_rd  <= (req_op == OP_RD);
            prog   <= prog_op;
            polled <= 1'b0;
            tmo    <= 1'b0;
            words  <= req_count;
            raddr  <= req_addr;
            rbit   <= '0;
          end
        end
        S_SEND: if (tick) begin
          if (!mem_sk) mem_sk <= 1'b1;
          else begin
            mem_sk <= 1'b0;
            sh     <= {sh[FW-2:0], 1'b0};
            bitn   <= bitn - NW'(1);
            if (bitn == NW'(1)) begin
              if (is_rd) state <= S_READ;
              else begin
                state  <= S_GAP;
                mem_cs <= 1'b0;
                gcnt   <= '0;
              end
            end
          end
        end
        S_READ: if (tick) begin
          if (!mem_sk) mem_sk <= 1'b1;
          else begin
            mem_sk <= 1'b0;
            rsh    <= {rsh[DW-2:0], mem_do};
            rbit   <= rbit + BW'(1);
            if (rbit == BW'(DW - 1)) begin
              rd_valid <= 1'b1;
              rd_data  <= {rsh[DW-2:0], mem_do};
              rd_addr  <= raddr;
              raddr    <= raddr + AW'(1);
              words    <= words - CW'(1);
              if (words == CW'(1)) begin
                state  <= S_GAP;
                mem_cs <= 1'b0;
                gcnt   <= '0;
              end
            end
          end
        end
        S_GAP: begin
          gcnt <= gcnt + GW'(1);
          if (gcnt == GW'(CSMIN - 1)) begin
            if (prog && !polled) begin
              state  <= S_POLL;
              mem_cs <= 1'b1;
              pcnt   <= '0;
            end else begin
              state <= S_IDLE;
              done  <= 1'b1;
              err   <= tmo;
            end
          end
        end
        S_POLL: if (tick) begin
          if (mem_do) state <= S_CLR;
          else if (pcnt == PW'(POLL_LIM - 1)) begin
            tmo    <= 1'b1;
            polled <= 1'b1;
            mem_cs <= 1'b0;
            gcnt   <= '0;
            state  <= S_GAP;
          end else pcnt <= pcnt + PW'(1);
        end
        S_CLR: if (tick) begin
          if (!mem_sk) mem_sk <= 1'b1;
          else begin
            mem_sk <= 1'b0;
            mem_cs <= 1'b0;
            polled <= 1'b1;
            gcnt   <= '0;
            state  <= S_GAP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [GW-1:0] lowlen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      lowlen <= '0;
    else if (mem_cs)                 lowlen <= '0;
    else if (lowlen != GW'(CSMIN))   lowlen <= lowlen + GW'(1);

  a_r1_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r1_no_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_di_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sk) |-> $stable(mem_di));
  a_r3_sk_low_on_cs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs) || $fell(mem_cs)) |-> !mem_sk);
  a_r6_min_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs) && state == S_POLL) |-> (lowlen == GW'(CSMIN)));
  a_r8_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

// File: tb/sim_ee_serial_host.sv
module sim_ee_serial_host;
  localparam int DIV = 2, CSMIN = 5, PLIM = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [8:0] req_count = '0;
  logic busy, done, err, rd_valid, mem_cs, mem_sk, mem_di, mem_do;
  logic [15:0] rd_data;
  logic [7:0] rd_addr;

  always #10 clk = ~clk;

  ee_serial_host #(.DIV(DIV), .CSMIN(CSMIN), .POLL_LIM(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
    .busy(busy), .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_addr(rd_addr), .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_di(mem_di), .mem_do(mem_do));

  int nvec = 0, nfail = 0;
  bit finished = 0;
  int cyc = 0;
  always @(negedge clk) cyc++;

  function automatic logic [15:0] initval(int i);
    return 16'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  // memory model
  int busy_len = 40;
  int busy_end = 0;
  logic [15:0] mdl [256];
  logic m_wen = 0, m_dout = 0;
  int m_mode = 0;
  logic [26:0] fr_bits = '0;
  int fr_n = 0, gap = 0, poll_rises = 0;
  logic poll_di = 0;
  assign mem_do = (m_mode == 3) ? m_dout : (mem_cs ? (cyc >= busy_end) : 1'b0);

  initial begin
    logic [25:0] msh;
    int mn, pend, rpos, t_fall;
    logic [7:0] ma, raddr;
    logic [15:0] rword;
    bit arm, in_poll;
    pend = 0; mn = 0; rpos = 15; t_fall = 0; ma = 0; raddr = 0; rword = 0;
    arm = 0; in_poll = 0; msh = 0;
    for (int i = 0; i < 256; i++) mdl[i] = initval(i);
    forever begin
      @(posedge mem_sk or posedge mem_cs or negedge mem_cs);
      if (!mem_cs) begin
        t_fall = cyc;
        if (in_poll) in_poll = 0;
        else if (pend != 0) begin
          if (m_wen) begin
            case (pend)
              1: mdl[ma] = msh[15:0];
              2: mdl[ma] = 16'hFFFF;
              3: for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
              default: for (int i = 0; i < 256; i++) mdl[i] = msh[15:0];
            endcase
            busy_end = cyc + busy_len;
          end
          arm = 1;
        end
        pend = 0; m_mode = 0; m_dout = 0;
      end else if (!mem_sk) begin
        if (arm) begin arm = 0; in_poll = 1; gap = cyc - t_fall; poll_rises = 0; end
        else fr_n = 0;
        m_mode = 0;
      end else if (in_poll) begin
        poll_rises++; poll_di = mem_di;
      end else begin
        fr_bits = {fr_bits[25:0], mem_di}; fr_n++;
        case (m_mode)
          0: if (mem_di) begin m_mode = 1; mn = 0; end
          1: begin
            msh = {msh[24:0], mem_di}; mn++;
            if (mn == 10) begin
              ma = msh[7:0];
              case (msh[9:8])
                2'b10: begin m_mode = 3; m_dout = 0; raddr = ma; rword = mdl[ma]; rpos = 15; end
                2'b01: begin m_mode = 2; mn = 0; pend = 1; end
                2'b11: begin m_mode = 4; pend = 2; end
                default: case (ma[7:6])
                  2'b11: begin m_wen = 1; m_mode = 4; end
                  2'b00: begin m_wen = 0; m_mode = 4; end
                  2'b10: begin pend = 3; m_mode = 4; end
                  default: begin pend = 4; m_mode = 2; mn = 0; end
                endcase
              endcase
            end
          end
          2: begin
            msh = {msh[24:0], mem_di}; mn++;
            if (mn == 16) m_mode = 4;
          end
          3: begin
            m_dout = rword[rpos];
            if (rpos == 0) begin raddr = raddr + 8'd1; rword = mdl[raddr]; rpos = 15; end
            else rpos--;
          end
          default: ;
        endcase
      end
    end
  end

  // monitors
  logic [15:0] got_d [2048];
  logic [7:0]  got_a [2048];
  int ngot = 0, cs_rises = 0, min_half = 1000000, run_len = 0;
  logic csq = 0, skq = 0;
  always @(posedge clk) begin
    if (rd_valid && ngot < 2048) begin got_d[ngot] = rd_data; got_a[ngot] = rd_addr; ngot++; end
    if (mem_cs && !csq) cs_rises++;
    csq = mem_cs;
    if (mem_sk != skq) begin if (run_len < min_half) min_half = run_len; run_len = 1; end
    else run_len++;
    skq = mem_sk;
  end

  // reference
  logic [15:0] ref_mem [256];
  logic ref_wen = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d,
                         input int cnt, output logic e, output bit saw_busy);
    int lim;
    bit got;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_count = 9'(cnt); req_valid = 1;
    got = 0; saw_busy = 0; e = 0; lim = 0;
    while (!got && lim < 30000) begin
      @(negedge clk);
      req_valid = 0;
      if (busy) saw_busy = 1;
      if (done) begin got = 1; e = err; end
      lim++;
    end
    if (!got) chk(0, "R1 done never seen", 0, 1);
    if (op == 3'd3) ref_wen = 1;
    if (op == 3'd4) ref_wen = 0;
    if (ref_wen) case (op)
      3'd1: ref_mem[a] = d;
      3'd2: ref_mem[a] = 16'hFFFF;
      3'd5: for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
      3'd6: for (int i = 0; i < 256; i++) ref_mem[i] = d;
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [7:0] a, input int cnt);
    logic e; bit sb; int base; logic [7:0] ea;
    base = ngot;
    run_cmd(3'd0, a, 16'h0, cnt, e, sb);
    chk(ngot - base == cnt, "R4 word count", ngot - base, cnt);
    for (int i = 0; i < cnt; i++) begin
      ea = 8'(a + i);
      chk(got_d[base + i] == ref_mem[ea], "R4 read data", got_d[base + i], ref_mem[ea]);
      chk(got_a[base + i] == ea, "R5 read address", got_a[base + i], ea);
    end
  endtask

  task automatic do_prog(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    logic e; bit sb;
    run_cmd(op, a, d, 0, e, sb);
    chk(e == 0, "R7 no error on ready", e, 0);
    chk(gap >= CSMIN, "R6 deselect gap", gap, CSMIN);
    chk(poll_rises == 1 && poll_di == 1, "R7 release pulse", poll_rises, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic e; bit sb; int c0; int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 256; i++) ref_mem[i] = initval(i);
    repeat (3) @(negedge clk);
    chk(!mem_cs && !mem_sk && !mem_di && !busy && !done && !rd_valid, "R1 reset state",
        {mem_cs, mem_sk, mem_di, busy, done, rd_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    do_read(8'd3, 1);
    do_prog(3'd1, 8'd5, 16'h1111);
    do_read(8'd5, 1);

    c0 = cs_rises;
    run_cmd(3'd3, 8'd0, 16'h0, 0, e, sb);
    chk(fr_n == 11 && fr_bits[10:0] == 11'b1_00_11000000, "R2 enable frame", fr_bits[10:0], 11'b10011000000);
    chk(cs_rises - c0 == 1, "R9 no poll after enable", cs_rises - c0, 1);

    do_prog(3'd1, 8'd20, 16'hBEEF);
    chk(fr_n == 27 && fr_bits == {1'b1, 2'b01, 8'd20, 16'hBEEF}, "R2 write frame", fr_bits, {1'b1, 2'b01, 8'd20, 16'hBEEF});
    do_read(8'd19, 3);

    for (int k = 0; k < 40; k++) begin
      int r;
      r = $urandom % 3;
      if (r == 0) do_prog(3'd1, 8'($urandom), 16'($urandom));
      else if (r == 1) do_prog(3'd2, 8'($urandom), 16'h0);
      else do_read(8'($urandom), 1 + ($urandom % 8));
    end

    do_read(8'd253, 6);

    // R1: request while busy is dropped
    do_prog(3'd1, 8'd10, 16'h1234);
    @(negedge clk);
    req_op = 3'd1; req_addr = 8'd9; req_wdata = 16'h5555; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (5) @(negedge clk);
    chk(busy == 1, "R1 busy during command", busy, 1);
    req_op = 3'd2; req_addr = 8'd10; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    ref_mem[9] = 16'h5555;
    c0 = cs_rises;
    repeat (100) @(negedge clk);
    chk(busy == 0 && cs_rises == c0, "R1 refused request idle", busy, 0);
    do_read(8'd9, 2);

    // R8 timeout
    busy_len = 1000;
    run_cmd(3'd2, 8'd77, 16'h0, 0, e, sb);
    chk(e == 1, "R8 poll timeout error", e, 1);
    chk(mem_cs == 0, "R8 deselected after timeout", mem_cs, 0);
    repeat (1100) @(negedge clk);
    busy_len = 40;
    do_read(8'd76, 3);

    do_prog(3'd6, 8'd0, 16'h3C5A);
    chk(fr_n == 27 && fr_bits == {3'b100, 8'b01000000, 16'h3C5A}, "R2 write-all frame", fr_bits, {3'b100, 8'b01000000, 16'h3C5A});
    do_read(8'd0, 256);
    do_prog(3'd5, 8'd0, 16'h0);
    do_read(8'd250, 10);

    run_cmd(3'd4, 8'd0, 16'h0, 0, e, sb);
    chk(fr_n == 11 && fr_bits[10:0] == 11'b1_00_00000000, "R2 disable frame", fr_bits[10:0], 11'b10000000000);
    do_prog(3'd1, 8'd7, 16'h7777);
    do_read(8'd7, 1);

    c0 = cs_rises;
    run_cmd(3'd0, 8'd4, 16'h0, 0, e, sb);
    chk(!sb && e == 0 && cs_rises == c0, "R10 zero-count read", cs_rises - c0, 0);
    run_cmd(3'd7, 8'd4, 16'h0, 0, e, sb);
    chk(!sb && e == 1 && cs_rises == c0, "R10 bad op error", e, 1);

    chk(min_half >= DIV, "R3 half period", min_half, DIV);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule